// File: doc/BRIEF.md
# IDE Bus Master Control Register

This block is the per-channel control and status word of a DMA bus master that serves one IDE/ATA channel. Software reads and writes it through a simple register port: an address compared against a fixed offset, read and write strobes, and byte enables. Software uses it to start a transfer, choose its direction, clear sticky status, and stop a transfer in flight. The block drives an enable, a direction bit and an abort pulse toward the DMA engine. It gathers the engine's state, the FIFO state, the device interrupt line and an external watchdog flag into the same 32-bit word.

The completion flag has two meanings. While the master is enabled, it latches a completion event and software clears it by writing 1. While the master is disabled, it shows the live device interrupt line. The block also guards the channel's task-file and PIO data registers: while the master is enabled, any access to them is answered with a target-abort.

Top module: `ide_bm_ctrl`

## Requirements
- R1: After reset, with the FIFO-empty input high and every other input low, a read returns 0x0008_0000. `reg_rdata` is zero whenever no read hits the register's offset (default 0x18).
- R2: Bit 0 is the master enable. It is written through byte lane 0, read back, and driven on `dma_en` from the cycle after the write.
- R3: Bit 3 is the direction: 1 moves data from the device to memory, 0 from memory to the device. It is written through byte lane 0, read back, and driven on `dma_to_mem`.
- R4: Bit 16 (active) reads 1 in the cycle after a clock edge at which the enable was set, the engine reported active, and no finish was reported. It reads 0 whenever the enable is 0.
- R5: Bit 17 (error) sets on an engine bus error while enabled. Writing 1 to it through lane 2 clears it. A set and a clear in the same cycle leave it set.
- R6: Bit 18 (complete) in device-to-memory mode sets only when the device interrupt is high and the engine has reported its finish at some point since the enable was set (or in the same cycle).
- R7: Bit 18 in memory-to-device mode sets on the device interrupt alone. While enabled, writing 1 to it through lane 2 clears it, and a same-cycle set wins over the clear.
- R8: While the enable is 0, bit 18 reads the live device interrupt line, and no latched completion survives into the next enable.
- R9: Bit 19 reads the live FIFO-empty input and bit 20 reads the live watchdog input.
- R10: Bits 22:21 are read/write through lane 2 with no effect on any output. Bit 23 and bits 31:24, 15:4 and 2:1 always read 0.
- R11: A write that clears the enable while bit 16 is 1 produces a `dma_abort` pulse exactly one cycle wide, in the cycle after the write. The same write clears the active, completion and finish-seen state.
- R12: `tf_target_abort` is high in the same cycle as `tf_access` exactly when the enable is set.
- R13: Only byte lanes whose enable bit is set change state. Writes through lanes 1 and 3, and writes to any other offset, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (8) | Register port address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (same cycle in the default build) |
| eng_active | input | 1 | DMA engine is moving data |
| eng_done | input | 1 | Engine has finished all data of the transfer |
| eng_bus_err | input | 1 | Bus error seen while mastering |
| fifo_empty | input | 1 | Channel FIFO is empty |
| dev_irq | input | 1 | Device interrupt line |
| wdog_flag | input | 1 | External watchdog status |
| tf_access | input | 1 | Access to the task-file or PIO data registers |
| tf_target_abort | output | 1 | Refuse that access with a target-abort |
| dma_en | output | 1 | Master enable toward the engine |
| dma_to_mem | output | 1 | Direction toward the engine |
| dma_abort | output | 1 | One-cycle abort-and-discard pulse |

## Verification
The hardest state to reach is an abort. It needs the enable set, then the engine held active long enough for bit 16 to latch, and then a lane-0 write of 0 before any finish report arrives. Completion in device-to-memory mode is similarly tricky, because the interrupt and the finish report can arrive in either order. The stimulus keeps `eng_active` high with a strong bias and makes `eng_done` rare, so that random enable writes often land while a transfer is running. Directed sequences then place the finish report before, with and after the interrupt, and line up a write-1 clear with a set in the same cycle.

// File: rtl/ide_bmc_pkg.sv
package ide_bmc_pkg;
   localparam int unsigned REG_W       = 32;
   localparam int unsigned BE_W        = REG_W / 8;
   localparam int unsigned BIT_EN      = 0;
   localparam int unsigned BIT_DIR     = 3;
   localparam int unsigned BIT_ACT     = 16;
   localparam int unsigned BIT_ERR     = 17;
   localparam int unsigned BIT_CMP     = 18;
   localparam int unsigned BIT_FIFO    = 19;
   localparam int unsigned BIT_WDOG    = 20;
   localparam int unsigned BIT_CAP_LO  = 21;
   localparam int unsigned BIT_SIMPLEX = 23;
   localparam int unsigned CAP_W       = 2;

   // decoded write request for one clock
   typedef struct packed {
      logic             lane_ctl;   // lane holding enable and direction
      logic             lane_sts;   // lane holding status and capability bits
      logic             en_val;
      logic             dir_val;
      logic [CAP_W-1:0] cap_val;
      logic             clr_err;
      logic             clr_cmp;
   } bmc_wreq_t;

   typedef struct packed {
      logic             en;
      logic             dir;
      logic [CAP_W-1:0] cap;
   } bmc_ctrl_t;

   typedef struct packed {
      logic act;
      logic err;
      logic cmp;
   } bmc_stat_t;
endpackage

// File: rtl/bmc_wr_decode.sv
module bmc_wr_decode
   import ide_bmc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned REG_OFFSET = 'h18
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [BE_W-1:0]   be,
   input  logic [REG_W-1:0]  wdata,
   output bmc_wreq_t         wreq,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);
   localparam int unsigned LANE_CTL = BIT_EN / 8;
   localparam int unsigned LANE_STS = BIT_ACT / 8;

   logic            hit;
   logic [BE_W-1:0] lane_wr;

   assign hit    = (addr == OFF);
   assign rd_hit = rd & hit;

   for (genvar gl = 0; gl < BE_W; gl++) begin : g_lane
      assign lane_wr[gl] = wr & hit & be[gl];
   end

   always_comb begin
      wreq          = '0;
      wreq.lane_ctl = lane_wr[LANE_CTL];
      wreq.lane_sts = lane_wr[LANE_STS];
      wreq.en_val   = wdata[BIT_EN];
      wreq.dir_val  = wdata[BIT_DIR];
      wreq.cap_val  = wdata[BIT_CAP_LO +: CAP_W];
      wreq.clr_err  = lane_wr[LANE_STS] & wdata[BIT_ERR];
      wreq.clr_cmp  = lane_wr[LANE_STS] & wdata[BIT_CMP];
   end

   logic wdata_unused;
   assign wdata_unused = ^{wdata[REG_W-1:BIT_SIMPLEX], wdata[BIT_WDOG:BIT_ACT],
                           wdata[BIT_ACT-1:BIT_DIR+1], wdata[BIT_DIR-1:BIT_EN+1]};
endmodule

// File: rtl/bmc_ctrl_regs.sv
module bmc_ctrl_regs
   import ide_bmc_pkg::*;
#(
   parameter logic [CAP_W-1:0] CAP_RST = '0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  bmc_wreq_t wreq,
   input  logic      act_q,
   output bmc_ctrl_t ctrl_q,
   output logic      en_next,
   output logic      abort_q
);
   logic abort_req;

   assign en_next   = wreq.lane_ctl ? wreq.en_val : ctrl_q.en;
   assign abort_req = wreq.lane_ctl & ~wreq.en_val & ctrl_q.en & act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q.en  <= 1'b0;
         ctrl_q.dir <= 1'b0;
         ctrl_q.cap <= CAP_RST;
         abort_q    <= 1'b0;
      end else begin
         ctrl_q.en <= en_next;
         if (wreq.lane_ctl) ctrl_q.dir <= wreq.dir_val;
         if (wreq.lane_sts) ctrl_q.cap <= wreq.cap_val;
         abort_q <= abort_req;
      end
   end
endmodule

// File: rtl/bmc_status.sv
module bmc_status
   import ide_bmc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  bmc_wreq_t wreq,
   input  logic      en_q,
   input  logic      en_next,
   input  logic      dir_q,
   input  logic      eng_active,
   input  logic      eng_done,
   input  logic      eng_bus_err,
   input  logic      dev_irq,
   output bmc_stat_t stat_q,
   output logic      done_seen_q
);
   logic drained;
   logic cmp_set;
   logic err_set;

   assign drained = done_seen_q | eng_done;
   assign cmp_set = en_q & dev_irq & (dir_q ? drained : 1'b1);
   assign err_set = en_q & eng_bus_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q      <= '0;
         done_seen_q <= 1'b0;
      end else begin
         done_seen_q <= en_next & drained;
         stat_q.act  <= en_next & eng_active & ~eng_done;
         if (err_set)           stat_q.err <= 1'b1;
         else if (wreq.clr_err) stat_q.err <= 1'b0;
         if (!en_next)          stat_q.cmp <= 1'b0;
         else if (cmp_set)      stat_q.cmp <= 1'b1;
         else if (wreq.clr_cmp) stat_q.cmp <= 1'b0;
      end
   end
endmodule

// File: rtl/ide_bm_ctrl.sv
module ide_bm_ctrl
   import ide_bmc_pkg::*;
#(
   parameter int unsigned      ADDR_W     = 8,
   parameter int unsigned      REG_OFFSET = 'h18,
   parameter bit               READ_REG   = 1'b0,
   parameter logic [CAP_W-1:0] CAP_RST    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [3:0]        reg_be,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              eng_active,
   input  logic              eng_done,
   input  logic              eng_bus_err,
   input  logic              fifo_empty,
   input  logic              dev_irq,
   input  logic              wdog_flag,
   input  logic              tf_access,
   output logic              tf_target_abort,
   output logic              dma_en,
   output logic              dma_to_mem,
   output logic              dma_abort
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ide_bm_ctrl: ADDR_W too small for a word offset");
   end
   if ((REG_OFFSET % 4) != 0 || REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_off
      $error("ide_bm_ctrl: REG_OFFSET must be word aligned and addressable");
   end

   bmc_wreq_t   wreq;
   bmc_ctrl_t   ctrl_q;
   bmc_stat_t   stat_q;
   logic        rd_hit;
   logic        en_next;
   logic        done_seen_q;
   logic        abort_q;
   logic [31:0] word;

   bmc_wr_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
      .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .be(reg_be),
      .wdata(reg_wdata), .wreq(wreq), .rd_hit(rd_hit)
   );

   bmc_ctrl_regs #(.CAP_RST(CAP_RST)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wreq(wreq), .act_q(stat_q.act),
      .ctrl_q(ctrl_q), .en_next(en_next), .abort_q(abort_q)
   );

   bmc_status u_sts (
      .clk(clk), .rst_n(rst_n), .wreq(wreq), .en_q(ctrl_q.en), .en_next(en_next),
      .dir_q(ctrl_q.dir), .eng_active(eng_active), .eng_done(eng_done),
      .eng_bus_err(eng_bus_err), .dev_irq(dev_irq),
      .stat_q(stat_q), .done_seen_q(done_seen_q)
   );

   always_comb begin
      word                          = '0;
      word[BIT_EN]                  = ctrl_q.en;
      word[BIT_DIR]                 = ctrl_q.dir;
      word[BIT_ACT]                 = stat_q.act;
      word[BIT_ERR]                 = stat_q.err;
      word[BIT_CMP]                 = ctrl_q.en ? stat_q.cmp : dev_irq;
      word[BIT_FIFO]                = fifo_empty;
      word[BIT_WDOG]                = wdog_flag;
      word[BIT_CAP_LO +: CAP_W]     = ctrl_q.cap;
   end

   if (READ_REG) begin : g_rd_reg
      logic [31:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_hit ? word : '0;
      end
      assign reg_rdata = rdata_q;
   end else begin : g_rd_comb
      assign reg_rdata = rd_hit ? word : '0;
   end

   assign dma_en          = ctrl_q.en;
   assign dma_to_mem      = ctrl_q.dir;
   assign dma_abort       = abort_q;
   assign tf_target_abort = tf_access & ctrl_q.en;
endmodule

// File: rtl/ide_bm_ctrl_chk.sv
module ide_bm_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic dma_en,
   input logic dma_to_mem,
   input logic dma_abort,
   input logic tf_access,
   input logic tf_target_abort,
   input logic eng_bus_err,
   input logic dev_irq,
   input logic act_q,
   input logic err_q,
   input logic cmp_q
);
   a_r11_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort |=> !dma_abort);
   a_r11_abort_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort |-> (!dma_en && $past(dma_en)));
   a_r12_tf_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (tf_access && dma_en) |-> tf_target_abort);
   a_r12_tf_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !tf_target_abort);
   a_r4_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !act_q);
   a_r5_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && eng_bus_err) |=> err_q);
   a_r7_cmp_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && !dma_to_mem && dev_irq) |=> (cmp_q || !dma_en));
   a_r8_no_latch_off: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !cmp_q);
endmodule

bind ide_bm_ctrl ide_bm_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dma_to_mem(dma_to_mem),
   .dma_abort(dma_abort), .tf_access(tf_access), .tf_target_abort(tf_target_abort),
   .eng_bus_err(eng_bus_err), .dev_irq(dev_irq),
   .act_q(stat_q.act), .err_q(stat_q.err), .cmp_q(stat_q.cmp)
);

// File: tb/ide_bm_ctrl_bench.sv
`timescale 1ns/1ps
module ide_bm_ctrl_bench;
   localparam logic [7:0] OFF = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 0, reg_rd = 0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_active = 0, eng_done = 0, eng_bus_err = 0;
   logic        fifo_empty = 1, dev_irq = 0, wdog_flag = 0, tf_access = 0;
   logic        tf_target_abort, dma_en, dma_to_mem, dma_abort;

   always #2 clk = ~clk;

   ide_bm_ctrl u_ide_bm_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_active(eng_active), .eng_done(eng_done), .eng_bus_err(eng_bus_err),
      .fifo_empty(fifo_empty), .dev_irq(dev_irq), .wdog_flag(wdog_flag),
      .tf_access(tf_access), .tf_target_abort(tf_target_abort),
      .dma_en(dma_en), .dma_to_mem(dma_to_mem), .dma_abort(dma_abort)
   );

   int  errors = 0;
   int  checks = 0;
   bit  finished = 0;

   // staged stimulus for the next cycle
   logic [7:0]  s_addr;
   logic        s_wr, s_rd, s_act, s_done, s_berr, s_fifo, s_irq, s_wdog, s_tf;
   logic [3:0]  s_be;
   logic [31:0] s_wd;

   // model state
   logic m_en, m_dir, m_act, m_err, m_cmp, m_seen, m_abort;
   logic [1:0] m_cap;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_word();
      logic [31:0] w = '0;
      w[0]     = m_en;
      w[3]     = m_dir;
      w[16]    = m_act;
      w[17]    = m_err;
      w[18]    = m_en ? m_cmp : s_irq;
      w[19]    = s_fifo;
      w[20]    = s_wdog;
      w[22:21] = m_cap;
      return w;
   endfunction

   task automatic model_reset();
      m_en = 0; m_dir = 0; m_act = 0; m_err = 0; m_cmp = 0; m_seen = 0; m_abort = 0;
      m_cap = '0;
   endtask

   task automatic idle_stage();
      s_addr = OFF; s_wr = 0; s_rd = 0; s_be = 0; s_wd = 0;
      s_act = 0; s_done = 0; s_berr = 0; s_fifo = 1; s_irq = 0; s_wdog = 0; s_tf = 0;
   endtask

   task automatic tick();
      logic hit, l0, l2, en_n, setc, drained;
      logic [31:0] w, e;
      @(negedge clk);
      chk("R2 dma_en", {31'b0, dma_en}, {31'b0, m_en});
      chk("R3 dma_to_mem", {31'b0, dma_to_mem}, {31'b0, m_dir});
      chk("R11 dma_abort", {31'b0, dma_abort}, {31'b0, m_abort});
      reg_addr = s_addr; reg_wr = s_wr; reg_rd = s_rd; reg_be = s_be; reg_wdata = s_wd;
      eng_active = s_act; eng_done = s_done; eng_bus_err = s_berr; fifo_empty = s_fifo;
      dev_irq = s_irq; wdog_flag = s_wdog; tf_access = s_tf;
      #1;
      chk("R12 tf_target_abort", {31'b0, tf_target_abort}, {31'b0, s_tf & m_en});
      hit = (s_addr == OFF);
      if (s_rd && hit) begin
         w = reg_rdata; e = exp_word();
         chk("R2 enable bit", {31'b0, w[0]}, {31'b0, e[0]});
         chk("R3 direction bit", {31'b0, w[3]}, {31'b0, e[3]});
         chk("R4 active bit", {31'b0, w[16]}, {31'b0, e[16]});
         chk("R5 error bit", {31'b0, w[17]}, {31'b0, e[17]});
         chk(m_en ? (m_dir ? "R6 complete bit" : "R7 complete bit") : "R8 irq mirror",
             {31'b0, w[18]}, {31'b0, e[18]});
         chk("R9 fifo/watchdog bits", {30'b0, w[20:19]}, {30'b0, e[20:19]});
         chk("R10 cap and zero bits", {w[31:21], 15'b0, w[15:4], w[2:1], 1'b0},
             {e[31:21], 15'b0, 12'b0, 2'b0, 1'b0});
      end else begin
         chk("R1 idle read data", reg_rdata, 32'h0);
      end
      // model next state
      l0 = s_wr & hit & s_be[0];
      l2 = s_wr & hit & s_be[2];
      en_n = l0 ? s_wd[0] : m_en;
      drained = m_seen | s_done;
      setc = m_en & s_irq & (m_dir ? drained : 1'b1);
      m_abort = l0 & ~s_wd[0] & m_en & m_act;
      m_act = en_n & s_act & ~s_done;
      m_seen = en_n & drained;
      if (m_en & s_berr) m_err = 1; else if (l2 & s_wd[17]) m_err = 0;
      if (!en_n) m_cmp = 0; else if (setc) m_cmp = 1; else if (l2 & s_wd[18]) m_cmp = 0;
      if (l0) m_dir = s_wd[3];
      if (l2) m_cap = s_wd[22:21];
      m_en = en_n;
   endtask

   task automatic wr_reg(input logic [3:0] be, input logic [31:0] d);
      s_wr = 1; s_be = be; s_wd = d; s_addr = OFF; tick(); s_wr = 0; s_be = 0;
   endtask

   task automatic rd_reg();
      s_rd = 1; s_addr = OFF; tick(); s_rd = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      model_reset();
      idle_stage();
      repeat (3) @(negedge clk);
      @(negedge clk) rst_n = 1;
      // R1: reset word
      reg_rd = 1; reg_addr = OFF; #1;
      chk("R1 reset value", reg_rdata, 32'h0008_0000);
      reg_rd = 0; #1;
      chk("R1 no read zero", reg_rdata, 32'h0);

      // R13: lanes 1 and 3, and zero byte enables, change nothing
      wr_reg(4'b1010, 32'hFFFF_FFFF);
      wr_reg(4'b0000, 32'hFFFF_FFFF);
      s_addr = 8'h1C; s_wr = 1; s_be = 4'hF; s_wd = 32'hFFFF_FFFF; tick(); s_wr = 0;
      rd_reg();
      chk("R13 ignored writes", {31'b0, m_en | m_dir | (|m_cap)}, 32'h0);

      // R8: disabled completion mirrors irq
      s_irq = 1; rd_reg(); s_irq = 0; rd_reg();

      // R6: device-to-memory, irq before finish
      wr_reg(4'b0001, 32'h9);
      s_act = 1; s_irq = 1; tick(); rd_reg();
      s_done = 1; tick(); s_done = 0; s_act = 0; rd_reg();
      chk("R6 complete after drain", {31'b0, m_cmp}, 32'h1);
      // R7 style clear in device-to-memory with irq dropped, then finish-before-irq
      s_irq = 0; wr_reg(4'b0100, 32'h0004_0000); rd_reg();
      s_irq = 1; rd_reg(); s_irq = 0;

      // R7: memory-to-device, set wins over clear in same cycle
      wr_reg(4'b0001, 32'h1);
      s_irq = 1; wr_reg(4'b0100, 32'h0004_0000); rd_reg();
      s_irq = 0; wr_reg(4'b0100, 32'h0004_0000); rd_reg();
      // R5: error set and clear in same cycle
      s_berr = 1; wr_reg(4'b0100, 32'h0002_0000); s_berr = 0; rd_reg();
      wr_reg(4'b0100, 32'h0002_0000); rd_reg();

      // R11: abort while active
      s_act = 1; tick(); tick(); rd_reg();
      s_tf = 1; tick(); s_tf = 0;
      wr_reg(4'b0001, 32'h0); s_act = 0;
      tick(); tick(); rd_reg();
      // R12 after disable
      s_tf = 1; tick(); s_tf = 0;

      // R10: capability bits
      wr_reg(4'b0100, 32'h00E0_0000); rd_reg();

      // R9: live bits
      s_fifo = 0; s_wdog = 1; rd_reg(); s_fifo = 1; s_wdog = 0;

      // random phase
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 99);
         s_addr = (r < 80) ? OFF : 8'($urandom);
         s_wr = ($urandom_range(0, 9) < 3);
         s_rd = ($urandom_range(0, 9) < 5);
         s_be = 4'($urandom);
         s_wd = $urandom;
         if ($urandom_range(0, 3) == 0) s_wd[0] = 1'b1;
         s_act = ($urandom_range(0, 9) < 7);
         s_done = ($urandom_range(0, 19) == 0);
         s_berr = ($urandom_range(0, 15) == 0);
         s_fifo = $urandom_range(0, 1);
         s_irq = ($urandom_range(0, 4) == 0);
         s_wdog = ($urandom_range(0, 7) == 0);
         s_tf = $urandom_range(0, 1);
         tick();
      end
      idle_stage();
      tick(); tick();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule